// File: doc/BRIEF.md
# Logical-to-Physical Width Adapter

This block turns one logical memory access from a processor core into a short burst of narrow transfers on an external parallel bus. A logical word is either 16 or 24 bits wide. The bus is either 8 or 16 bits wide. When the two widths differ, one logical location covers several physical locations. The adapter scales the logical address by that ratio, clips the result to the address bits that the attached device really has, and then walks through consecutive physical addresses. On writes it slices the word into bus-sized pieces. On reads it reassembles those pieces into one word.

The core raises `req_valid` for one cycle, together with the address, data, direction and the two width selects. The adapter then drives the bus strobe, address and write data from registers. The attached device completes each transfer by asserting `bus_ack`. After the last transfer, `done` pulses for one cycle, and for a read `rd_data` holds the assembled word. Bank decoding and wait-state generation are left to the surrounding logic. Wait states appear to this block only as cycles in which `bus_ack` is low.

Top module: `width_adapter`

## Requirements
- R1: The number of bus transfers per access is 2 for a 16-bit word on the 8-bit bus, 4 for a 24-bit word on the 8-bit bus, 1 for a 16-bit word on the 16-bit bus, and 2 for a 24-bit word on the 16-bit bus. The selects are encoded as follows: `req_word24`=1 means a 24-bit word, and `req_bus16`=1 means the 16-bit bus.
- R2: The first transfer address is the logical address times the transfer count of R1, truncated to PADDR_W bits, with every bit at or above position `dev_abits` cleared. A `dev_abits` of 0, or of PADDR_W or more, disables the clearing. Example: a 16-bit word at 0x011000 on the 8-bit bus with `dev_abits`=16 starts at 0x002000.
- R3: Each following transfer uses the previous address plus one, wrapped within the device mask, so that no bit at or above `dev_abits` is ever set.
- R4: Pieces go out least-significant first. On the 8-bit bus, transfer i carries byte i of the word on `bus_wdata[7:0]` with `bus_wdata[15:8]`=0, and the fourth byte of a 24-bit word is 0.
- R5: For a 24-bit word on the 16-bit bus, transfer 0 carries bits 15:0 and transfer 1 carries {8'h00, bits 23:16}.
- R6: For a 16-bit access, `req_wdata[23:16]` has no effect on the bus, and `rd_data[23:16]` reads as 0.
- R7: Reads ignore the bus lanes that do not belong to the word: `bus_rdata[15:8]` on the 8-bit bus, the whole fourth byte of a 24-bit word on the 8-bit bus, and `bus_rdata[15:8]` of the second transfer of a 24-bit word on the 16-bit bus.
- R8: `done` is high for exactly one cycle, the cycle after the clock edge at which the last transfer is acknowledged. For reads, `rd_data` holds the assembled word in that cycle. With `bus_ack` held high, `done` appears N+1 cycles after the request edge, where N is the transfer count.
- R9: While `bus_ack` is low, the strobe, `bus_addr` and `bus_wdata` hold their values. A transfer completes at a rising edge where the strobe and `bus_ack` are both high.
- R10: `busy` is high from the cycle after a request is accepted until `done`. A `req_valid` while `busy` is high is ignored. `bus_rd` and `bus_wr` are never high together.
- R11: After reset, `busy`, `done`, `bus_rd` and `bus_wr` are 0 and `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle access request from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | LADDR_W | Logical word address |
| req_wdata | input | 24 | Logical write data |
| req_word24 | input | 1 | 1 = 24-bit logical word, 0 = 16-bit |
| req_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| dev_abits | input | ABITS_W | Address bits present on the device (0 = all) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 24 | Assembled read word |
| bus_addr | output | PADDR_W | Physical bus address |
| bus_wdata | output | 16 | Physical write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Physical read data |
| bus_ack | input | 1 | Transfer completion from the device |

## Verification
A wrong beat index shows up at the ports at once. Within the same access, a byte or half-word lands on the wrong address or the wrong lane, and on a read the word comes back scrambled. A wrong latched width or mask gives the wrong transfer count. The core sees this within one access: `done` comes early or late against the N+1 cycle latency, or an address has bits set above `dev_abits`. A hold fault under a low `bus_ack` moves the address in the middle of a transfer, so the recorded beat addresses no longer form a consecutive run.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int WORD_W = 24;
  localparam int BUSW   = 16;

  typedef enum logic {ST_IDLE, ST_XFER} wa_state_e;

  // transfers per logical access
  function automatic logic [2:0] beats_of(input logic w24, input logic b16);
    if (b16) return w24 ? 3'd2 : 3'd1;
    return w24 ? 3'd4 : 3'd2;
  endfunction

  // log2 of the transfer count
  function automatic logic [1:0] shift_of(input logic w24, input logic b16);
    if (b16) return w24 ? 2'd1 : 2'd0;
    return w24 ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/wa_addr_gen.sv
module wa_addr_gen #(
  parameter int LADDR_W = 24,
  parameter int PADDR_W = 24,
  parameter int ABITS_W = $clog2(PADDR_W + 1)
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic [1:0]         shift,
  input  logic [ABITS_W-1:0] abits,
  input  logic [1:0]         idx,
  output logic [PADDR_W-1:0] mask,
  output logic [PADDR_W-1:0] paddr
);
  localparam int WIDE_W = LADDR_W + PADDR_W + 2;

  logic [WIDE_W-1:0]  wide;
  logic [PADDR_W-1:0] scaled;
  logic               full;

  assign full   = (abits == '0) || (32'(abits) >= PADDR_W);
  assign wide   = WIDE_W'(laddr) << shift;
  assign scaled = wide[PADDR_W-1:0];

  for (genvar b = 0; b < PADDR_W; b++) begin : g_mask
    assign mask[b] = full || (b < 32'(abits));
  end

  assign paddr = ((scaled & mask) + PADDR_W'(idx)) & mask;
endmodule

// File: rtl/wa_wr_pack.sv
module wa_wr_pack
  import wa_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  input  logic              w24,
  input  logic              b16,
  input  logic [1:0]        idx,
  output logic [BUSW-1:0]   beat
);
  logic [31:0] word32;

  assign word32 = {8'h00, (w24 ? wdata[23:16] : 8'h00), wdata[15:0]};

  always_comb begin
    if (b16) beat = word32[{idx[0], 4'b0} +: 16];
    else     beat = {8'h00, word32[{idx, 3'b0} +: 8]};
  end
endmodule

// File: rtl/wa_rd_merge.sv
module wa_rd_merge
  import wa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat_ok,
  input  logic [1:0]        idx,
  input  logic              w24,
  input  logic              b16,
  input  logic [BUSW-1:0]   rdata,
  output logic [WORD_W-1:0] merged
);
  logic [31:0] acc_q, acc_n;

  always_comb begin
    acc_n = acc_q;
    if (b16) acc_n[{idx[0], 4'b0} +: 16] = rdata;
    else     acc_n[{idx, 3'b0} +: 8]     = rdata[7:0];
  end

  assign merged = w24 ? acc_n[23:0] : {8'h00, acc_n[15:0]};

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (beat_ok) acc_q <= acc_n;
  end
endmodule

// File: rtl/width_adapter.sv
module width_adapter
  import wa_pkg::*;
#(
  parameter int LADDR_W = 24,
  parameter int PADDR_W = 24,
  parameter int ABITS_W = $clog2(PADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [23:0]        req_wdata,
  input  logic               req_word24,
  input  logic               req_bus16,
  input  logic [ABITS_W-1:0] dev_abits,
  output logic               busy,
  output logic               done,
  output logic [23:0]        rd_data,
  output logic [PADDR_W-1:0] bus_addr,
  output logic [15:0]        bus_wdata,
  output logic               bus_rd,
  output logic               bus_wr,
  input  logic [15:0]        bus_rdata,
  input  logic               bus_ack
);
  wa_state_e          state_q;
  logic [LADDR_W-1:0] laddr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               w24_q, b16_q, wr_q;
  logic [ABITS_W-1:0] abits_q;
  logic [1:0]         idx_q;
  logic [PADDR_W-1:0] mask_q;

  logic               idle, accept, beat_ok, last;
  logic [LADDR_W-1:0] sel_laddr;
  logic [WORD_W-1:0]  sel_wdata;
  logic               sel_w24, sel_b16;
  logic [ABITS_W-1:0] sel_abits;
  logic [1:0]         next_idx;
  logic [PADDR_W-1:0] gen_addr, gen_mask;
  logic [BUSW-1:0]    gen_wdata;
  logic [WORD_W-1:0]  merged;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_valid;
  assign beat_ok   = !idle && bus_ack;
  assign last      = ({1'b0, idx_q} == beats_of(w24_q, b16_q) - 3'd1);
  assign sel_laddr = idle ? req_addr   : laddr_q;
  assign sel_wdata = idle ? req_wdata  : wdata_q;
  assign sel_w24   = idle ? req_word24 : w24_q;
  assign sel_b16   = idle ? req_bus16  : b16_q;
  assign sel_abits = idle ? dev_abits  : abits_q;
  assign next_idx  = idle ? 2'd0 : idx_q + 2'd1;
  assign busy      = !idle;

  wa_addr_gen #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W), .ABITS_W(ABITS_W)) addr_i (
    .laddr(sel_laddr), .shift(shift_of(sel_w24, sel_b16)), .abits(sel_abits),
    .idx(next_idx), .mask(gen_mask), .paddr(gen_addr));

  wa_wr_pack pack_i (
    .wdata(sel_wdata), .w24(sel_w24), .b16(sel_b16), .idx(next_idx), .beat(gen_wdata));

  wa_rd_merge merge_i (
    .clk(clk), .rst(rst), .clear(accept), .beat_ok(beat_ok), .idx(idx_q),
    .w24(w24_q), .b16(b16_q), .rdata(bus_rdata), .merged(merged));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      laddr_q   <= '0;
      wdata_q   <= '0;
      w24_q     <= 1'b0;
      b16_q     <= 1'b0;
      wr_q      <= 1'b0;
      abits_q   <= '0;
      idx_q     <= '0;
      mask_q    <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (idle) begin
        if (req_valid) begin
          state_q   <= ST_XFER;
          laddr_q   <= req_addr;
          wdata_q   <= req_wdata;
          w24_q     <= req_word24;
          b16_q     <= req_bus16;
          wr_q      <= req_write;
          abits_q   <= dev_abits;
          idx_q     <= 2'd0;
          mask_q    <= gen_mask;
          bus_addr  <= gen_addr;
          bus_wdata <= req_write ? gen_wdata : '0;
          bus_rd    <= !req_write;
          bus_wr    <= req_write;
        end
      end else if (bus_ack) begin
        if (last) begin
          state_q   <= ST_IDLE;
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b0;
          bus_wdata <= '0;
          done      <= 1'b1;
          if (!wr_q) rd_data <= merged;
        end else begin
          idx_q     <= next_idx;
          bus_addr  <= gen_addr;
          bus_wdata <= wr_q ? gen_wdata : '0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (!idle && bus_ack && last) |=> (done && !bus_rd && !bus_wr)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr)); // R10
  AST_ADDR_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> ((bus_addr & ~mask_q) == '0)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!idle && bus_ack && !last) |=> (bus_addr == (($past(bus_addr) + 1'b1) & mask_q))); // R3
  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!idle && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata) && (bus_rd || bus_wr))); // R9
  AST_NARROW_LANE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !b16_q) |-> (bus_wdata[15:8] == 8'h00)); // R4
endmodule

// File: tb/width_adapter_tb_top.sv
`timescale 1ns/1ps
module width_adapter_tb_top;
  localparam int PW = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_word24 = 0, req_bus16 = 0;
  logic [23:0] req_addr = '0, req_wdata = '0;
  logic [4:0]  dev_abits = '0;
  logic busy, done, bus_rd, bus_wr;
  logic [23:0] rd_data;
  logic [PW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic ack_en = 1'b1;
  logic bus_ack;

  int checks = 0, errors = 0;
  logic [15:0] mem [0:1023];
  logic cur_b16 = 1'b0;
  int nbeat = 0;
  logic [PW-1:0] b_addr [0:63];
  logic [15:0]   b_data [0:63];

  always #5 clk = ~clk;

  assign bus_ack   = (bus_rd || bus_wr) && ack_en;
  assign bus_rdata = mem[bus_addr[9:0]];

  width_adapter dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_word24(req_word24),
    .req_bus16(req_bus16), .dev_abits(dev_abits), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  always @(posedge clk) begin
    if (!rst && bus_ack) begin
      b_addr[nbeat[5:0]] <= bus_addr;
      b_data[nbeat[5:0]] <= bus_wdata;
      nbeat <= nbeat + 1;
      if (bus_wr) mem[bus_addr[9:0]] <= cur_b16 ? bus_wdata : {8'hA5, bus_wdata[7:0]};
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [23:0] la, input logic [23:0] wd,
                       input bit w24, input bit b16, input logic [4:0] ab,
                       input bit slow, input bit stray, output logic [23:0] rdv,
                       output logic [PW-1:0] a0);
    int f, sh, start, lat, n;
    logic [PW-1:0] mask, base;
    logic [31:0] w32, expd;
    bit got;
    f  = b16 ? (w24 ? 2 : 1) : (w24 ? 4 : 2);
    sh = b16 ? (w24 ? 1 : 0) : (w24 ? 2 : 1);
    mask = (ab == 0 || ab >= PW) ? {PW{1'b1}} : PW'((25'd1 << ab) - 1);
    base = PW'({8'h0, la} << sh) & mask;
    w32  = {8'h00, (w24 ? wd[23:16] : 8'h00), wd[15:0]};
    @(negedge clk);
    cur_b16 = b16; start = nbeat;
    req_valid = 1; req_write = wr; req_addr = la; req_wdata = wd;
    req_word24 = w24; req_bus16 = b16; dev_abits = ab;
    lat = 0; got = 0;
    for (int c = 0; c < 64 && !got; c++) begin
      @(negedge clk);
      if (slow) ack_en = ~ack_en;
      lat++;
      if (stray && lat == 1) begin
        req_valid = 1; req_write = ~wr; req_addr = la ^ 24'h000055;
        req_wdata = ~wd; req_word24 = ~w24; req_bus16 = ~b16;
      end else req_valid = 0;
      if (lat == 1) check("R10 busy after accept", {31'd0, busy}, 32'd1);
      if (done) got = 1;
    end
    req_valid = 0; ack_en = 1;
    check("R8 done seen", {31'd0, got}, 32'd1);
    if (!slow) check("R8 latency", lat, f + 1);
    rdv = rd_data;
    n = nbeat - start;
    check("R1 transfer count", n, f);
    a0 = b_addr[start[5:0]];
    check("R2 start address", a0, base);
    for (int i = 0; i < f && i < n; i++) begin
      check("R3 beat address", b_addr[(start + i) % 64], (base + PW'(i)) & mask);
      if (wr) begin
        expd = b16 ? ((w32 >> (16 * i)) & 32'hFFFF) : ((w32 >> (8 * i)) & 32'hFF);
        check(b16 ? (w24 ? "R5 wide lane" : "R6 wide word") : "R4 narrow lane",
              {16'h0, b_data[(start + i) % 64]}, expd);
      end
    end
    @(negedge clk);
    check("R8 done one cycle", {31'd0, done}, 32'd0);
    check("R10 idle after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] rv, wd;
    logic [PW-1:0] a0;
    int k, f;
    logic [4:0] abl [0:3];
    logic [23:0] lal [0:3];
    abl[0] = 5'd1; abl[1] = 5'd4; abl[2] = 5'd10; abl[3] = 5'd0;
    lal[0] = 24'h000000; lal[1] = 24'h000001; lal[2] = 24'h000037; lal[3] = 24'h123456;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h3B1D);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    check("R11 reset busy", {31'd0, busy}, 0);
    check("R11 reset done", {31'd0, done}, 0);
    check("R11 reset strobes", {30'd0, bus_rd, bus_wr}, 0);
    check("R11 reset addr", {8'd0, bus_addr}, 0);

    k = 0;
    for (int m = 0; m < 4; m++) begin
      for (int ai = 0; ai < 4; ai++) begin
        for (int li = 0; li < 4; li++) begin
          bit w24, b16;
          w24 = m[0]; b16 = m[1];
          f = b16 ? (w24 ? 2 : 1) : (w24 ? 4 : 2);
          wd = 24'hA1B2C3 ^ 24'(k * 24'h010307);
          k++;
          do_op(1, lal[li], wd, w24, b16, abl[ai], 0, (k % 3) == 0, rv, a0);
          if (abl[ai] == 0 || f <= (1 << abl[ai])) begin
            // junk in lanes that must be ignored on read
            if (w24 && !b16) mem[10'(a0 + 3) & 10'((abl[ai] == 0 || abl[ai] >= 10) ? 10'h3FF : (10'd1 << abl[ai]) - 1)] = 16'hBEEF;
            if (w24 && b16) mem[10'(a0 + 1) & 10'((abl[ai] == 0 || abl[ai] >= 10) ? 10'h3FF : (10'd1 << abl[ai]) - 1)][15:8] = 8'h5A;
            do_op(0, lal[li], 24'h0, w24, b16, abl[ai], 0, 0, rv, a0);
            check(w24 ? "R7 read word" : "R6 read upper zero", {8'h0, rv},
                  {8'h0, w24 ? wd : {8'h00, wd[15:0]}});
          end
        end
      end
    end

    // documented scaling example
    do_op(1, 24'h011000, 24'h00BEEF, 0, 0, 5'd16, 0, 0, rv, a0);
    check("R2 example address", {8'h0, a0}, 32'h002000);

    // slow device: acknowledges every other cycle
    for (int m = 0; m < 4; m++) begin
      wd = 24'h5C3A91 + 24'(m);
      do_op(1, 24'h000021, wd, m[0], m[1], 5'd10, 1, 0, rv, a0);
      do_op(0, 24'h000021, 24'h0, m[0], m[1], 5'd10, 1, 0, rv, a0);
      check("R9 slow round trip", {8'h0, rv}, {8'h0, m[0] ? wd : {8'h00, wd[15:0]}});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule